// File: doc/BRIEF.md
# Edge-Selectable External Interrupt Controller

This block collects interrupt events from pins outside the chip. Three edge channels each have their own edge selection, their own sticky flag and their own interrupt request. The selection for each channel is rising edge, falling edge, both edges or off. A separate bank of eight wake-up inputs responds to a high level only. Each of these inputs has its own enable bit and its own flag bit, and the bank drives a single request line. Software configures and services the block through four byte-wide registers on a simple write strobe plus combinational read port.

When the power controller marks the system as sleeping or stopped, the block asserts a wake-up request whenever an enabled request exists. In stop mode the clock may be halted. An enabled edge is then caught by a latch that sets asynchronously and raises the wake-up request at once. When the clock restarts, the latched event is carried into the normal flag through a synchroniser, so no event is lost. In running mode every pin passes through a two-flop synchroniser before detection. Rewriting the edge selection blanks detection for one cycle so that the mode change cannot create a false event.

Top module: `xint_ctrl`

## Requirements
- R1: Register 0 holds the edge selection. Channel c uses bits [2c+1:2c], where bit 2c enables rising-edge detection and bit 2c+1 enables falling-edge detection: 00 is off, 01 rising, 10 falling, 11 both. The register reads back as written.
- R2: On a selected transition of ext_i[c], the channel flag is set. The flags read at register 1 bits [6:4], and the channel enables are in register 1 bits [2:0]. A transition that is not selected leaves the flag unchanged.
- R3: A flag stays set until software writes register 1 with a 0 in that flag's bit. Writing a 1 to a flag bit leaves the flag unchanged.
- R4: If a detected event and a clearing write fall in the same cycle, the flag ends up set.
- R5: irq_o[c] is high exactly when flag c and enable c are both set. A flag is recorded even while its channel is disabled.
- R6: A pin change made between clock edges shows in the flag and in irq_o on the third rising clock edge after the change, not before. A pulse held for two clock cycles is always caught.
- R7: A channel selected as off never sets its flag, whatever its pin does.
- R8: A write to register 0 blanks edge detection for the cycle that follows the write. An edge whose detection falls in that cycle is dropped.
- R9: While stop_i is high, an enabled selected edge raises wake_o with no clock running. The event sets the channel flag once the clock has restarted. An event on a disabled channel does not raise wake_o.
- R10: Register 2 holds the level-input enables and register 3 holds the level flags, one bit per input. A flag is set while its synchronised input is high, and a write of 0 clears it only once the input is low. lvl_irq_o is the OR of the flags that are enabled.
- R11: wake_o is low unless sleep_i or stop_i is high. While either is high, wake_o follows any active irq_o bit or lvl_irq_o. In stop mode it also follows any enabled wk_i input directly.
- R12: After reset all registers read 0 and irq_o, lvl_irq_o and wake_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, may be halted in stop mode |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_i | input | 1 | System is in sleep mode |
| stop_i | input | 1 | System is in stop mode (clock may be stopped) |
| ext_i | input | 3 | Edge-detected interrupt pins |
| wk_i | input | 8 | Level-detected wake-up pins, active high |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i |
| irq_o | output | 3 | Per-channel interrupt requests |
| lvl_irq_o | output | 1 | Level bank interrupt request |
| wake_o | output | 1 | Wake-up request to the power controller |

## Verification
A pin change driven between edges reaches a flag, a register read and irq_o on the third rising edge: two edges go to synchronisation and one to the flag register. The bench therefore checks one cycle before and one cycle on that edge. A register write is visible one edge after its strobe. The asynchronous stop-mode wake is checked a fraction of a cycle after the pin moves, with the clock held off. The restart path allows six edges for the latch resynchroniser. The set-versus-clear and blanking cases place the write strobe so that its capturing edge lands exactly on the edge where the detection would complete. Every expected item is checked half a cycle after its drive edge.

// File: rtl/xint_pkg.sv
`timescale 1ns/1ps
package xint_pkg;
  localparam int unsigned REG_AW       = 2;
  localparam int unsigned REG_DW       = 8;
  localparam int unsigned CTL_FLAG_LSB = 4;

  typedef enum logic [REG_AW-1:0] {
    A_SEL = 2'd0,
    A_CTL = 2'd1,
    A_LEN = 2'd2,
    A_LFL = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic fall;
    logic rise;
  } edge_mode_t;
endpackage

// File: rtl/xint_sync.sv
`timescale 1ns/1ps
module xint_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [STAGES-1:0][W-1:0] st_d;

  always_comb begin
    st_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      st_d[i] = st_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/xint_edge_chan.sv
`timescale 1ns/1ps
module xint_edge_chan
  import xint_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  edge_mode_t mode_i,
  input  logic       blank_i,
  input  logic       stop_i,
  input  logic       clr_i,
  output logic       flag_o,
  output logic       pend_o
);
  logic pin_s;
  logic prev_q, prev_d;
  logic hit;
  logic set_async;
  logic pend_q;
  logic pend_s;
  logic pend_old_q, pend_old_d;
  logic pend_pulse;
  logic flag_q, flag_d;

  xint_sync #(.STAGES(SYNC_STAGES), .W(1)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  xint_sync #(.STAGES(SYNC_STAGES), .W(1)) u_pend_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pend_q),
    .q_o   (pend_s)
  );

  // prev_q freezes when the clock stops, so a raw pin that differs from it
  // marks an edge that happened during stop.
  always_comb begin
    prev_d     = pin_s;
    pend_old_d = pend_s;
    hit        = !blank_i &&
                 ((mode_i.rise && pin_s && !prev_q) ||
                  (mode_i.fall && !pin_s && prev_q));
    set_async  = stop_i &&
                 ((mode_i.rise && pin_i && !prev_q) ||
                  (mode_i.fall && !pin_i && prev_q));
    pend_pulse = pend_s && !pend_old_q;
    flag_d     = hit || pend_pulse || (flag_q && !clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q     <= 1'b0;
      pend_old_q <= 1'b0;
      flag_q     <= 1'b0;
    end else begin
      prev_q     <= prev_d;
      pend_old_q <= pend_old_d;
      flag_q     <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n or posedge set_async) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (set_async) begin
      pend_q <= 1'b1;
    end else if (pend_s) begin
      pend_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/xint_wake_bank.sv
`timescale 1ns/1ps
module xint_wake_bank #(
  parameter int unsigned N           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] lvl_s;
  logic [N-1:0] flag_q, flag_d;

  xint_sync #(.STAGES(SYNC_STAGES), .W(N)) u_lvl_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (lvl_i),
    .q_o   (lvl_s)
  );

  always_comb begin
    flag_d = lvl_s | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/xint_ctrl.sv
`timescale 1ns/1ps
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int unsigned N_EDGE      = 3,
  parameter int unsigned N_WAKE      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_i,
  input  logic              stop_i,
  input  logic [N_EDGE-1:0] ext_i,
  input  logic [N_WAKE-1:0] wk_i,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_DW-1:0] wdata_i,
  output logic [REG_DW-1:0] rdata_o,
  output logic [N_EDGE-1:0] irq_o,
  output logic              lvl_irq_o,
  output logic              wake_o
);
  localparam int unsigned SEL_W = 2 * N_EDGE;

  logic [1:0]        rst_pipe_q, rst_pipe_d;
  logic              rst_sync_n;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic [N_EDGE-1:0] en_q, en_d;
  logic [N_WAKE-1:0] wen_q, wen_d;
  logic              blank_q, blank_d;
  logic              wr_sel, wr_ctl, wr_len, wr_lfl;
  logic [N_EDGE-1:0] edge_clr;
  logic [N_WAKE-1:0] wake_clr;
  logic [N_EDGE-1:0] edge_flag;
  logic [N_EDGE-1:0] edge_pend;
  logic [N_WAKE-1:0] wake_flag;
  logic              any_req;
  logic              stop_wake;

  // reset: asserted at once, released on the second clock edge
  always_comb rst_pipe_d = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  // register writes
  always_comb begin
    wr_sel   = wr_i && (reg_addr_e'(addr_i) == A_SEL);
    wr_ctl   = wr_i && (reg_addr_e'(addr_i) == A_CTL);
    wr_len   = wr_i && (reg_addr_e'(addr_i) == A_LEN);
    wr_lfl   = wr_i && (reg_addr_e'(addr_i) == A_LFL);
    sel_d    = wr_sel ? wdata_i[SEL_W-1:0] : sel_q;
    en_d     = wr_ctl ? wdata_i[N_EDGE-1:0] : en_q;
    wen_d    = wr_len ? wdata_i[N_WAKE-1:0] : wen_q;
    blank_d  = wr_sel;
    edge_clr = wr_ctl ? ~wdata_i[CTL_FLAG_LSB +: N_EDGE] : '0;
    wake_clr = wr_lfl ? ~wdata_i[N_WAKE-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q   <= '0;
      en_q    <= '0;
      wen_q   <= '0;
      blank_q <= 1'b0;
    end else begin
      sel_q   <= sel_d;
      en_q    <= en_d;
      wen_q   <= wen_d;
      blank_q <= blank_d;
    end
  end

  for (genvar c = 0; c < N_EDGE; c++) begin : g_chan
    xint_edge_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pin_i   (ext_i[c]),
      .mode_i  (edge_mode_t'(sel_q[2*c +: 2])),
      .blank_i (blank_q),
      .stop_i  (stop_i),
      .clr_i   (edge_clr[c]),
      .flag_o  (edge_flag[c]),
      .pend_o  (edge_pend[c])
    );
  end

  xint_wake_bank #(.N(N_WAKE), .SYNC_STAGES(SYNC_STAGES)) u_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (wk_i),
    .clr_i  (wake_clr),
    .flag_o (wake_flag)
  );

  // read port
  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      A_SEL: rdata_o[SEL_W-1:0] = sel_q;
      A_CTL: begin
        rdata_o[N_EDGE-1:0]              = en_q;
        rdata_o[CTL_FLAG_LSB +: N_EDGE]  = edge_flag;
      end
      A_LEN: rdata_o[N_WAKE-1:0] = wen_q;
      A_LFL: rdata_o[N_WAKE-1:0] = wake_flag;
      default: rdata_o = '0;
    endcase
  end

  // requests
  always_comb begin
    irq_o     = edge_flag & en_q;
    lvl_irq_o = |(wake_flag & wen_q);
    any_req   = (|irq_o) || lvl_irq_o;
    stop_wake = (|(edge_pend & en_q)) || (|(wk_i & wen_q));
    wake_o    = (sleep_i || stop_i) && (any_req || (stop_i && stop_wake));
  end
endmodule

// File: rtl/xint_ctrl_chk.sv
`timescale 1ns/1ps
module xint_ctrl_chk #(
  parameter int unsigned N_EDGE = 3,
  parameter int unsigned N_WAKE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_i,
  input logic              wr_i,
  input logic [1:0]        addr_i,
  input logic [N_WAKE-1:0] wk_i,
  input logic [N_EDGE-1:0] irq_o,
  input logic              lvl_irq_o,
  input logic              wake_o,
  input logic [N_EDGE-1:0] edge_flag,
  input logic [N_WAKE-1:0] wake_flag
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (cyc_q != 2'd3) begin
      cyc_q <= cyc_q + 2'd1;
    end
  end

  // R3: edge flags only drop after a write to the control register
  a_r3_edge_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == 2'd1) |=> (($past(edge_flag) & ~edge_flag) == '0));

  // R10: level flags only drop after a write to the level flag register
  a_r10_lvl_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && addr_i == 2'd3) |=> (($past(wake_flag) & ~wake_flag) == '0));

  // R10: an input high for three samples has its flag set
  a_r10_lvl_flag_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q == 2'd3) |->
      ((($past(wk_i, 1) & $past(wk_i, 2) & $past(wk_i, 3)) & ~wake_flag) == '0));

  // R11: any request while sleeping raises the wake-up output
  a_r11_wake_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && (|irq_o)) |-> wake_o);

  // R11: the level request also raises the wake-up output while sleeping
  a_r11_wake_on_lvl: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i && lvl_irq_o) |-> wake_o);
endmodule

bind xint_ctrl xint_ctrl_chk #(.N_EDGE(N_EDGE), .N_WAKE(N_WAKE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sleep_i   (sleep_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wk_i      (wk_i),
  .irq_o     (irq_o),
  .lvl_irq_o (lvl_irq_o),
  .wake_o    (wake_o),
  .edge_flag (edge_flag),
  .wake_flag (wake_flag)
);

// File: tb/xint_ctrl_bench.sv
`timescale 1ns/1ps
module xint_ctrl_bench;
  logic       clk_raw = 1'b0;
  logic       clk_run = 1'b1;
  logic       clk;
  logic       rst_n;
  logic       sleep_i, stop_i;
  logic [2:0] ext_i;
  logic [7:0] wk_i;
  logic       wr_i;
  logic [1:0] addr_i;
  logic [7:0] wdata_i;
  logic [7:0] rdata_o;
  logic [2:0] irq_o;
  logic       lvl_irq_o, wake_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string      tag;
    logic [12:0] mask;
    logic [12:0] exp;
  } item_t;
  item_t sb_q[$];

  always #2 clk_raw = ~clk_raw;
  assign clk = clk_raw & clk_run;

  xint_ctrl u_xint_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_i   (sleep_i),
    .stop_i    (stop_i),
    .ext_i     (ext_i),
    .wk_i      (wk_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .irq_o     (irq_o),
    .lvl_irq_o (lvl_irq_o),
    .wake_o    (wake_o)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      #0.5;
      while (sb_q.size() != 0) begin
        item_t it;
        logic [12:0] obs;
        it  = sb_q.pop_front();
        obs = {wake_o, lvl_irq_o, irq_o, rdata_o};
        checks++;
        if ((obs & it.mask) !== (it.exp & it.mask)) begin
          errors++;
          $display("FAIL %s actual %h expected %h", it.tag, obs & it.mask, it.exp & it.mask);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk_raw);
    @(negedge clk_raw);
  endtask

  task automatic push(string tag, logic [12:0] mask, logic [12:0] exp);
    sb_q.push_back('{tag, mask, exp});
    #1;
    @(negedge clk_raw);
  endtask

  task automatic chk_reg(string tag, logic [1:0] a, logic [7:0] e);
    addr_i = a;
    push(tag, 13'h0FF, {5'b0, e});
  endtask

  task automatic chk_irq(string tag, logic [2:0] e);
    push(tag, 13'h700, {2'b0, e, 8'h00});
  endtask

  task automatic chk_lirq(string tag, logic e);
    push(tag, 13'h800, {1'b0, e, 11'h0});
  endtask

  task automatic chk_wake(string tag, logic e);
    push(tag, 13'h1000, {e, 12'h0});
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    addr_i  = a;
    wdata_i = d;
    wr_i    = 1'b1;
    @(posedge clk_raw);
    @(negedge clk_raw);
    wr_i    = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; sleep_i = 1'b0; stop_i = 1'b0;
    ext_i = '0; wk_i = '0; wr_i = 1'b0; addr_i = '0; wdata_i = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R12 reset state
    chk_reg("R12 sel reg", 2'd0, 8'h00);
    chk_reg("R12 ctl reg", 2'd1, 8'h00);
    chk_reg("R12 lvl en reg", 2'd2, 8'h00);
    chk_reg("R12 lvl flag reg", 2'd3, 8'h00);
    chk_irq("R12 irq", 3'b000);
    chk_lirq("R12 lvl irq", 1'b0);
    chk_wake("R12 wake", 1'b0);

    // R1 selection: ch0 rising, ch1 falling, ch2 both
    wr_reg(2'd0, 8'h39);
    chk_reg("R1 sel readback", 2'd0, 8'h39);
    wr_reg(2'd1, 8'h07);
    chk_reg("R1 enables readback", 2'd1, 8'h07);

    // R6 latency and R2 rising
    ext_i[0] = 1'b1;
    tick(2);
    chk_irq("R6 before third edge", 3'b000);
    chk_irq("R2 R6 rising ch0", 3'b001);

    // R2 falling only on ch1
    ext_i[1] = 1'b1;
    tick(4);
    chk_irq("R2 ch1 ignores rise", 3'b001);
    ext_i[1] = 1'b0;
    tick(3);
    chk_irq("R2 ch1 falling", 3'b011);

    // R2 both on ch2
    ext_i[2] = 1'b1;
    tick(3);
    chk_irq("R2 ch2 rise", 3'b111);
    wr_reg(2'd1, 8'h07);
    chk_reg("R3 write zero clears", 2'd1, 8'h07);
    ext_i[2] = 1'b0;
    ext_i[0] = 1'b0;
    tick(3);
    chk_irq("R2 ch2 fall, ch0 ignores fall", 3'b100);

    // R3 writing one keeps a flag
    wr_reg(2'd1, 8'h47);
    chk_reg("R3 write one keeps", 2'd1, 8'h47);
    wr_reg(2'd1, 8'h07);
    chk_reg("R3 cleared again", 2'd1, 8'h07);

    // R7 channel off
    wr_reg(2'd0, 8'h38);
    ext_i[0] = 1'b1;
    tick(3);
    chk_irq("R7 off ignores rise", 3'b000);
    ext_i[0] = 1'b0;
    tick(3);
    chk_irq("R7 off ignores fall", 3'b000);

    // R5 enable gating
    wr_reg(2'd0, 8'h39);
    wr_reg(2'd1, 8'h06);
    ext_i[0] = 1'b1;
    tick(3);
    chk_irq("R5 disabled no irq", 3'b000);
    chk_reg("R5 flag recorded", 2'd1, 8'h16);
    wr_reg(2'd1, 8'h17);
    chk_irq("R5 enabled irq", 3'b001);
    sleep_i = 1'b1;
    chk_wake("R11 wake in sleep", 1'b1);
    sleep_i = 1'b0;
    chk_wake("R11 no wake awake", 1'b0);
    wr_reg(2'd1, 8'h07);
    ext_i[0] = 1'b0;
    tick(3);

    // R4 set beats clear
    ext_i[0] = 1'b1;
    tick(3);
    ext_i[0] = 1'b0;
    tick(3);
    ext_i[0] = 1'b1;
    tick(2);
    wr_reg(2'd1, 8'h07);
    chk_reg("R4 set wins over clear", 2'd1, 8'h17);
    wr_reg(2'd1, 8'h07);
    chk_reg("R4 plain clear", 2'd1, 8'h07);
    ext_i[0] = 1'b0;
    tick(3);

    // R8 blanking after a selection write
    ext_i[0] = 1'b1;
    tick(1);
    wr_reg(2'd0, 8'h39);
    tick(3);
    chk_reg("R8 edge dropped", 2'd1, 8'h07);
    ext_i[0] = 1'b0;
    tick(3);
    ext_i[0] = 1'b1;
    tick(3);
    chk_irq("R8 detection resumes", 3'b001);
    wr_reg(2'd1, 8'h07);
    ext_i[0] = 1'b0;
    tick(3);

    // R6 two-cycle pulse
    ext_i[0] = 1'b1;
    tick(2);
    ext_i[0] = 1'b0;
    tick(3);
    chk_irq("R6 short pulse caught", 3'b001);
    wr_reg(2'd1, 8'h07);
    tick(2);

    // R10 level bank
    wr_reg(2'd2, 8'h08);
    wk_i[3] = 1'b1;
    tick(3);
    chk_reg("R10 level flag set", 2'd3, 8'h08);
    chk_lirq("R10 level irq", 1'b1);
    wr_reg(2'd3, 8'h00);
    chk_reg("R10 clear while high", 2'd3, 8'h08);
    wk_i[3] = 1'b0;
    tick(3);
    wr_reg(2'd3, 8'h00);
    chk_reg("R10 clear when low", 2'd3, 8'h00);
    chk_lirq("R10 irq drops", 1'b0);
    wk_i[5] = 1'b1;
    tick(3);
    chk_reg("R10 disabled input flag", 2'd3, 8'h20);
    chk_lirq("R10 disabled input no irq", 1'b0);
    wk_i[5] = 1'b0;
    tick(3);
    wr_reg(2'd3, 8'h00);
    wk_i[3] = 1'b1;
    tick(3);
    sleep_i = 1'b1;
    chk_wake("R11 level wake in sleep", 1'b1);
    sleep_i = 1'b0;
    wk_i[3] = 1'b0;
    tick(3);
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd2, 8'h00);

    // R9 stop mode with the clock halted
    wr_reg(2'd1, 8'h01);
    stop_i  = 1'b1;
    clk_run = 1'b0;
    #1;
    ext_i[0] = 1'b1;
    chk_wake("R9 wake with clock stopped", 1'b1);
    chk_reg("R9 no flag while stopped", 2'd1, 8'h01);
    clk_run = 1'b1;
    stop_i  = 1'b0;
    tick(6);
    chk_reg("R9 flag after restart", 2'd1, 8'h11);
    chk_wake("R9 no wake after exit", 1'b0);
    wr_reg(2'd1, 8'h01);
    tick(4);
    chk_reg("R9 latch consumed once", 2'd1, 8'h01);
    ext_i[0] = 1'b0;
    tick(3);

    // R9 disabled channel in stop
    ext_i[1] = 1'b1;
    tick(3);
    stop_i  = 1'b1;
    clk_run = 1'b0;
    #1;
    ext_i[1] = 1'b0;
    chk_wake("R9 disabled channel no wake", 1'b0);
    clk_run = 1'b1;
    stop_i  = 1'b0;
    tick(6);
    chk_reg("R9 disabled channel flag", 2'd1, 8'h21);
    wr_reg(2'd1, 8'h01);

    // R11 level input in stop
    wr_reg(2'd2, 8'h04);
    stop_i  = 1'b1;
    clk_run = 1'b0;
    #1;
    wk_i[2] = 1'b1;
    chk_wake("R11 level wake in stop", 1'b1);
    wk_i[2] = 1'b0;
    chk_wake("R11 level gone no wake", 1'b0);
    clk_run = 1'b1;
    stop_i  = 1'b0;
    tick(4);

    wait (sb_q.size() == 0);
    #2;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk_raw);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule